// File: doc/BRIEF.md
# Lock-Protected System Control Register Bank

This block is a small memory-mapped register bank that a board-level controller uses for its status and control functions. A processor reaches it over a plain 32-bit bus with a select, a write enable, a byte address and separate write and read data. Reads are combinational. Writes take effect on the clock edge at which select and write enable are both high. The bank holds a read-only identification word and a LED register that drives output pins. It has a lock register that opens when a magic key is written, and a reset-control register guarded by that lock which issues a one-cycle system reset request. It also has volatile and non-volatile flag words with separate set and clear addresses, a display-control register, a card-status word fed by two input lines, and a free-running tick counter.

The identification word is a parameter. Its 12-bit board-type field (bits 27:16) picks one of four variants at elaboration time:
- early-mux (code 0x100);
- early-plain (code 0x140);
- late (codes 0x178 and 0x182);
- other (every remaining code).

The variant decides three things: which bit of a reset-control write raises the reset request, which display bits software may change, and where the write-protect line appears in the card-status word.

There are two reset inputs. `pwr_rst` clears the whole bank. `rst` is a soft reset that leaves the non-volatile flags as they were. Both are synchronous and active high. The reset request output does not reset the bank itself; the surrounding system decides what to do with it.

Top module: `sysctl_bank`

## Requirements
- R1: Offset 0x00 returns ID_VALUE and ignores writes; bits 27:16 of ID_VALUE select the variant (0x100 early-mux, 0x140 early-plain, 0x178 or 0x182 late, anything else other); offset 0x84 returns PROC_ID and offset 0x88 returns 0xFF000000.
- R2: Offset 0x08 is a read/write 32-bit LED word, and `led_out` shows its low LED_W bits.
- R3: A write to offset 0x20 stores 0xA05F when the whole written word equals 0x0000A05F. Any other word stores its bits 14:0 with bit 15 zero. The lock reads back as that 16-bit value, zero-extended.
- R4: A write to offset 0x40 is accepted only while the lock holds 0xA05F and the variant is early-mux or late. An accepted write stores the whole word, which offset 0x40 reads back. On early-plain and other variants offset 0x40 always reads 0.
- R5: An accepted reset-control write raises `sys_rst_req` for exactly the one cycle after the write edge. The trigger is bit 8 of the written word on early-mux and bit 2 on late. The pulse leaves every register unchanged.
- R6: Writing offset 0x30 ORs the data into the flag word, and writing 0x34 clears the flag bits that are set in the data. Offset 0x30 reads the flags and offset 0x34 reads 0.
- R7: The non-volatile flags set at 0x38, clear at 0x3C and read at 0x38. Only `pwr_rst` clears them; `rst` leaves them unchanged.
- R8: `rst` or `pwr_rst` clears the LED word, the lock, the flags, the stored reset level and the tick counter, and returns the display word to its reset value.
- R9: The display word at 0x50 resets to 0x1F00 on early-mux, early-plain and late, and to 0 on other. On the early variants a write keeps bits 13:8 and takes the remaining bits from the data. On late a write keeps bit 7 and takes the remaining bits from the data. On other, writes are ignored.
- R10: On early-mux, `disp_fmt` equals bits 1:0 of the last accepted display write (0 after reset); on all other variants it is 0.
- R11: Offset 0x48 reads `card_present` in bit 0 and `card_wprot` in bit 2 on the early variants, or in bit 1 on late and other; all other bits are 0 and writes are ignored.
- R12: Every offset not named in R1 to R13 reads 0 and ignores writes, and offset 0x44 always reads 1.
- R13: Offset 0x5C reads a TICK_W-bit counter, zero-extended. It increments once per clock, wraps to 0 after its maximum without any flag, and reads 1 on the first cycle after a reset is released.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Soft reset, synchronous, active high; keeps the non-volatile flags |
| pwr_rst | input | 1 | Power-on reset, synchronous, active high; clears everything |
| bus_sel | input | 1 | Bus access select |
| bus_we | input | 1 | Write enable (1 = write, 0 = read) |
| bus_addr | input | ADDR_W | Byte offset of the access (word aligned) |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data; valid while bus_sel is high and bus_we is low, otherwise 0 |
| card_present | input | 1 | Card-detect line |
| card_wprot | input | 1 | Card write-protect line |
| led_out | output | LED_W | LED drive |
| disp_fmt | output | 2 | Display format select |
| sys_rst_req | output | 1 | One-cycle system reset request |

## Verification
The bench builds four copies of the bank side by side on one shared bus, with board-type codes 0x100, 0x140, 0x178 and 0x190, so that every access exercises all four variants at once. Each copy compares its lock, reset-trigger, display-mask and card-bit behaviour against a model computed in the bench. TICK_W is set to 8, which brings counter wraparound within a few hundred cycles. The address sweep covers every word offset from 0x00 to 0xFC plus several above that range, for reads and for ignored writes.

// File: rtl/sysctl_pkg.sv
package sysctl_pkg;

    typedef enum logic [1:0] {
        VAR_EARLY_MUX   = 2'd0,
        VAR_EARLY_PLAIN = 2'd1,
        VAR_LATE        = 2'd2,
        VAR_OTHER       = 2'd3
    } variant_e;

    localparam int unsigned WORD_W     = 32;
    localparam logic [15:0] UNLOCK_KEY = 16'hA05F;
    localparam logic [31:0] PCI_READ   = 32'h0000_0001;
    localparam logic [31:0] PROC1_READ = 32'hFF00_0000;

    localparam logic [7:0] OFS_ID     = 8'h00;
    localparam logic [7:0] OFS_LED    = 8'h08;
    localparam logic [7:0] OFS_LOCK   = 8'h20;
    localparam logic [7:0] OFS_FSET   = 8'h30;
    localparam logic [7:0] OFS_FCLR   = 8'h34;
    localparam logic [7:0] OFS_NVSET  = 8'h38;
    localparam logic [7:0] OFS_NVCLR  = 8'h3C;
    localparam logic [7:0] OFS_RSTCTL = 8'h40;
    localparam logic [7:0] OFS_PCI    = 8'h44;
    localparam logic [7:0] OFS_CARD   = 8'h48;
    localparam logic [7:0] OFS_DISP   = 8'h50;
    localparam logic [7:0] OFS_TICK   = 8'h5C;
    localparam logic [7:0] OFS_PROC0  = 8'h84;
    localparam logic [7:0] OFS_PROC1  = 8'h88;

    typedef struct packed {
        logic led;
        logic lock;
        logic rstctl;
        logic fset;
        logic fclr;
        logic nvset;
        logic nvclr;
        logic disp;
    } wr_strobe_t;

    function automatic variant_e variant_of(input logic [11:0] code);
        case (code)
            12'h100:          return VAR_EARLY_MUX;
            12'h140:          return VAR_EARLY_PLAIN;
            12'h178, 12'h182: return VAR_LATE;
            default:          return VAR_OTHER;
        endcase
    endfunction

    function automatic bit rstctl_enabled(input variant_e v);
        return (v == VAR_EARLY_MUX) || (v == VAR_LATE);
    endfunction

    function automatic int unsigned trigger_bit(input variant_e v);
        return (v == VAR_EARLY_MUX) ? 8 : 2;
    endfunction

    function automatic int unsigned wprot_bit(input variant_e v);
        return ((v == VAR_EARLY_MUX) || (v == VAR_EARLY_PLAIN)) ? 2 : 1;
    endfunction

    function automatic logic [WORD_W-1:0] disp_keep_mask(input variant_e v);
        case (v)
            VAR_EARLY_MUX, VAR_EARLY_PLAIN: return 32'h0000_3F00;
            VAR_LATE:                       return 32'h0000_0080;
            default:                        return 32'hFFFF_FFFF;
        endcase
    endfunction

    function automatic logic [WORD_W-1:0] disp_reset_value(input variant_e v);
        return (v == VAR_OTHER) ? 32'h0 : 32'h0000_1F00;
    endfunction

endpackage

// File: rtl/sysctl_setclr.sv
module sysctl_setclr #(
    parameter int unsigned W          = 32,
    parameter bit          SOFT_CLEAR = 1'b1
) (
    input  logic         clk,
    input  logic         pwr_rst,
    input  logic         soft_rst,
    input  logic         set_we,
    input  logic         clr_we,
    input  logic [W-1:0] wdata,
    output logic [W-1:0] value
);

    logic [W-1:0] value_q;
    logic         clear_now;

    assign clear_now = pwr_rst || (SOFT_CLEAR && soft_rst);

    always_ff @(posedge clk) begin
        if (clear_now) begin
            value_q <= '0;
        end else if (set_we) begin
            value_q <= value_q | wdata;
        end else if (clr_we) begin
            value_q <= value_q & ~wdata;
        end
    end

    assign value = value_q;

endmodule

// File: rtl/sysctl_lockrst.sv
module sysctl_lockrst
    import sysctl_pkg::*;
#(
    parameter variant_e VARIANT = VAR_OTHER
) (
    input  logic              clk,
    input  logic              rst_any,
    input  logic              lock_we,
    input  logic              rstctl_we,
    input  logic [WORD_W-1:0] wdata,
    output logic [15:0]       lock_q,
    output logic [WORD_W-1:0] level_q,
    output logic              req_o
);

    localparam bit          RST_EN = rstctl_enabled(VARIANT);
    localparam int unsigned TRIG   = trigger_bit(VARIANT);

    logic [15:0] lock_r;
    logic        unlocked;

    always_ff @(posedge clk) begin
        if (rst_any) begin
            lock_r <= '0;
        end else if (lock_we) begin
            if (wdata == {16'h0, UNLOCK_KEY}) begin
                lock_r <= UNLOCK_KEY;
            end else begin
                lock_r <= {1'b0, wdata[14:0]};
            end
        end
    end

    assign unlocked = (lock_r == UNLOCK_KEY);
    assign lock_q   = lock_r;

    generate
        if (RST_EN) begin : g_rstctl
            logic [WORD_W-1:0] level_r;
            logic              req_r;
            always_ff @(posedge clk) begin
                if (rst_any) begin
                    level_r <= '0;
                    req_r   <= 1'b0;
                end else begin
                    req_r <= 1'b0;
                    if (rstctl_we && unlocked) begin
                        level_r <= wdata;
                        req_r   <= wdata[TRIG];
                    end
                end
            end
            assign level_q = level_r;
            assign req_o   = req_r;
        end else begin : g_no_rstctl
            logic unused_rstctl;
            assign unused_rstctl = rstctl_we ^ unlocked;
            assign level_q       = '0;
            assign req_o         = 1'b0;
        end
    endgenerate

endmodule

// File: rtl/sysctl_display.sv
module sysctl_display
    import sysctl_pkg::*;
#(
    parameter variant_e VARIANT = VAR_OTHER
) (
    input  logic              clk,
    input  logic              rst_any,
    input  logic              we,
    input  logic [WORD_W-1:0] wdata,
    output logic [WORD_W-1:0] disp_q,
    output logic [1:0]        fmt_o
);

    localparam logic [WORD_W-1:0] KEEP  = disp_keep_mask(VARIANT);
    localparam logic [WORD_W-1:0] RSTV  = disp_reset_value(VARIANT);
    localparam bit                HAS_MUX = (VARIANT == VAR_EARLY_MUX);

    generate
        if (VARIANT == VAR_OTHER) begin : g_absent
            logic unused_disp;
            assign unused_disp = ^{clk, rst_any, we, wdata, KEEP};
            assign disp_q      = RSTV;
        end else begin : g_present
            logic [WORD_W-1:0] disp_r;
            always_ff @(posedge clk) begin
                if (rst_any) begin
                    disp_r <= RSTV;
                end else if (we) begin
                    disp_r <= (disp_r & KEEP) | (wdata & ~KEEP);
                end
            end
            assign disp_q = disp_r;
        end

        if (HAS_MUX) begin : g_mux
            assign fmt_o = disp_q[1:0];
        end else begin : g_no_mux
            assign fmt_o = 2'b00;
        end
    endgenerate

endmodule

// File: rtl/sysctl_tick.sv
module sysctl_tick #(
    parameter int unsigned TICK_W = 32
) (
    input  logic              clk,
    input  logic              rst_any,
    output logic [TICK_W-1:0] count
);

    logic [TICK_W-1:0] count_q;

    always_ff @(posedge clk) begin
        if (rst_any) begin
            count_q <= '0;
        end else begin
            count_q <= count_q + 1'b1;
        end
    end

    assign count = count_q;

endmodule

// File: rtl/sysctl_bank.sv
module sysctl_bank
    import sysctl_pkg::*;
#(
    parameter logic [31:0] ID_VALUE = 32'h0100_0000,
    parameter logic [31:0] PROC_ID  = 32'h0000_0000,
    parameter int unsigned ADDR_W   = 12,
    parameter int unsigned LED_W    = 8,
    parameter int unsigned TICK_W   = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              pwr_rst,
    input  logic              bus_sel,
    input  logic              bus_we,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [31:0]       bus_wdata,
    output logic [31:0]       bus_rdata,
    input  logic              card_present,
    input  logic              card_wprot,
    output logic [LED_W-1:0]  led_out,
    output logic [1:0]        disp_fmt,
    output logic              sys_rst_req
);

    localparam variant_e    VARIANT = variant_of(ID_VALUE[27:16]);
    localparam int unsigned WP_BIT  = wprot_bit(VARIANT);

    logic              rst_any;
    wr_strobe_t        wr_s;
    logic [WORD_W-1:0] led_q;
    logic [15:0]       lock_q;
    logic [WORD_W-1:0] level_q;
    logic [WORD_W-1:0] flags_q;
    logic [WORD_W-1:0] nv_q;
    logic [WORD_W-1:0] disp_q;
    logic [WORD_W-1:0] card_q;
    logic [TICK_W-1:0] tick_q;

    assign rst_any = rst | pwr_rst;

    function automatic logic at(input logic [7:0] ofs);
        return bus_addr == ADDR_W'(ofs);
    endfunction

    always_comb begin
        wr_s = '0;
        if (bus_sel && bus_we) begin
            wr_s.led    = at(OFS_LED);
            wr_s.lock   = at(OFS_LOCK);
            wr_s.rstctl = at(OFS_RSTCTL);
            wr_s.fset   = at(OFS_FSET);
            wr_s.fclr   = at(OFS_FCLR);
            wr_s.nvset  = at(OFS_NVSET);
            wr_s.nvclr  = at(OFS_NVCLR);
            wr_s.disp   = at(OFS_DISP);
        end
    end

    always_ff @(posedge clk) begin
        if (rst_any) begin
            led_q <= '0;
        end else if (wr_s.led) begin
            led_q <= bus_wdata;
        end
    end

    assign led_out = led_q[LED_W-1:0];

    sysctl_lockrst #(.VARIANT(VARIANT)) u_lockrst (
        .clk       (clk),
        .rst_any   (rst_any),
        .lock_we   (wr_s.lock),
        .rstctl_we (wr_s.rstctl),
        .wdata     (bus_wdata),
        .lock_q    (lock_q),
        .level_q   (level_q),
        .req_o     (sys_rst_req)
    );

    sysctl_setclr #(.W(WORD_W), .SOFT_CLEAR(1'b1)) u_flags (
        .clk      (clk),
        .pwr_rst  (pwr_rst),
        .soft_rst (rst),
        .set_we   (wr_s.fset),
        .clr_we   (wr_s.fclr),
        .wdata    (bus_wdata),
        .value    (flags_q)
    );

    sysctl_setclr #(.W(WORD_W), .SOFT_CLEAR(1'b0)) u_nvflags (
        .clk      (clk),
        .pwr_rst  (pwr_rst),
        .soft_rst (rst),
        .set_we   (wr_s.nvset),
        .clr_we   (wr_s.nvclr),
        .wdata    (bus_wdata),
        .value    (nv_q)
    );

    sysctl_display #(.VARIANT(VARIANT)) u_display (
        .clk     (clk),
        .rst_any (rst_any),
        .we      (wr_s.disp),
        .wdata   (bus_wdata),
        .disp_q  (disp_q),
        .fmt_o   (disp_fmt)
    );

    sysctl_tick #(.TICK_W(TICK_W)) u_tick (
        .clk     (clk),
        .rst_any (rst_any),
        .count   (tick_q)
    );

    always_comb begin
        card_q         = '0;
        card_q[0]      = card_present;
        card_q[WP_BIT] = card_wprot;
    end

    always_comb begin
        bus_rdata = '0;
        if (bus_sel && !bus_we) begin
            case (bus_addr)
                ADDR_W'(OFS_ID):     bus_rdata = ID_VALUE;
                ADDR_W'(OFS_LED):    bus_rdata = led_q;
                ADDR_W'(OFS_LOCK):   bus_rdata = {16'h0, lock_q};
                ADDR_W'(OFS_FSET):   bus_rdata = flags_q;
                ADDR_W'(OFS_NVSET):  bus_rdata = nv_q;
                ADDR_W'(OFS_RSTCTL): bus_rdata = level_q;
                ADDR_W'(OFS_PCI):    bus_rdata = PCI_READ;
                ADDR_W'(OFS_CARD):   bus_rdata = card_q;
                ADDR_W'(OFS_DISP):   bus_rdata = disp_q;
                ADDR_W'(OFS_TICK):   bus_rdata = WORD_W'(tick_q);
                ADDR_W'(OFS_PROC0):  bus_rdata = PROC_ID;
                ADDR_W'(OFS_PROC1):  bus_rdata = PROC1_READ;
                default:             bus_rdata = '0;
            endcase
        end
    end

endmodule

// File: rtl/sysctl_bank_chk.sv
module sysctl_bank_chk #(
    parameter int unsigned ADDR_W = 12
) (
    input logic              clk,
    input logic              rst,
    input logic              pwr_rst,
    input logic              bus_sel,
    input logic              bus_we,
    input logic [ADDR_W-1:0] bus_addr,
    input logic [31:0]       bus_rdata,
    input logic [1:0]        disp_fmt,
    input logic              sys_rst_req,
    input logic [15:0]       lock_q,
    input logic [31:0]       nv_q
);

    logic rd_acc;
    logic wr_rstctl_open;
    logic wr_disp;
    logic rd_reserved;

    assign rd_acc         = bus_sel && !bus_we;
    assign wr_rstctl_open = bus_sel && bus_we && (bus_addr == ADDR_W'(8'h40))
                            && (lock_q == 16'hA05F);
    assign wr_disp        = bus_sel && bus_we && (bus_addr == ADDR_W'(8'h50));
    assign rd_reserved    = rd_acc && ((bus_addr == ADDR_W'(8'h04)) ||
                                       (bus_addr == ADDR_W'(8'h24)) ||
                                       (bus_addr == ADDR_W'(8'h34)) ||
                                       (bus_addr == ADDR_W'(8'h60)));

    AST_REQ_ONE_CYCLE: assert property (@(posedge clk) disable iff (rst || pwr_rst)
        sys_rst_req |=> !sys_rst_req); // R5

    AST_REQ_NEEDS_OPEN_WRITE: assert property (@(posedge clk) disable iff (rst || pwr_rst)
        sys_rst_req |-> $past(wr_rstctl_open)); // R4

    AST_LOCK_BIT15_KEY_ONLY: assert property (@(posedge clk) disable iff (rst || pwr_rst)
        (rd_acc && bus_addr == ADDR_W'(8'h20) && bus_rdata[15]) |-> (bus_rdata == 32'h0000_A05F)); // R3

    AST_NV_KEPT_SOFT: assert property (@(posedge clk) disable iff (pwr_rst)
        rst |=> $stable(nv_q)); // R7

    AST_PCI_READS_ONE: assert property (@(posedge clk) disable iff (rst || pwr_rst)
        (rd_acc && bus_addr == ADDR_W'(8'h44)) |-> (bus_rdata == 32'h1)); // R12

    AST_RESERVED_ZERO: assert property (@(posedge clk) disable iff (rst || pwr_rst)
        rd_reserved |-> (bus_rdata == 32'h0)); // R12

    AST_FMT_HOLDS: assert property (@(posedge clk) disable iff (rst || pwr_rst)
        !wr_disp |=> $stable(disp_fmt)); // R10

endmodule

bind sysctl_bank sysctl_bank_chk #(.ADDR_W(ADDR_W)) u_chk (
    .clk         (clk),
    .rst         (rst),
    .pwr_rst     (pwr_rst),
    .bus_sel     (bus_sel),
    .bus_we      (bus_we),
    .bus_addr    (bus_addr),
    .bus_rdata   (bus_rdata),
    .disp_fmt    (disp_fmt),
    .sys_rst_req (sys_rst_req),
    .lock_q      (lock_q),
    .nv_q        (nv_q)
);

// File: tb/sysctl_bank_tb.sv
`timescale 1ns/1ps
module sysctl_bank_tb;

    localparam int NI = 4;
    localparam logic [31:0] IDS [NI] = '{32'h0100_0000, 32'h0140_0000,
                                         32'h0178_0000, 32'h0190_0000};

    logic        clk = 1'b0;
    logic        rst = 1'b0;
    logic        pwr_rst = 1'b1;
    logic        bus_sel = 1'b0;
    logic        bus_we = 1'b0;
    logic [11:0] bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic        card_present = 1'b0;
    logic        card_wprot = 1'b0;

    logic [31:0] rdata  [NI];
    logic [7:0]  led_o  [NI];
    logic [1:0]  fmt_o  [NI];
    logic [NI-1:0] req_o;

    int n_chk = 0;
    int n_err = 0;
    bit done = 1'b0;

    logic [31:0] rv   [NI];
    logic        reqv [NI];

    always #2.5 clk = ~clk;

    for (genvar i = 0; i < NI; i++) begin : g_var
        sysctl_bank #(
            .ID_VALUE (IDS[i]),
            .PROC_ID  (32'h0000_0011 + 32'(i)),
            .ADDR_W   (12),
            .LED_W    (8),
            .TICK_W   (8)
        ) u_dut (
            .clk          (clk),
            .rst          (rst),
            .pwr_rst      (pwr_rst),
            .bus_sel      (bus_sel),
            .bus_we       (bus_we),
            .bus_addr     (bus_addr),
            .bus_wdata    (bus_wdata),
            .bus_rdata    (rdata[i]),
            .card_present (card_present),
            .card_wprot   (card_wprot),
            .led_out      (led_o[i]),
            .disp_fmt     (fmt_o[i]),
            .sys_rst_req  (req_o[i])
        );
    end

    // 0 early-mux, 1 early-plain, 2 late, 3 other
    function automatic int kind(input int i);
        case (IDS[i][27:16])
            12'h100:          return 0;
            12'h140:          return 1;
            12'h178, 12'h182: return 2;
            default:          return 3;
        endcase
    endfunction

    task automatic chk(input string tag, input int inst, input logic [31:0] act,
                       input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s inst%0d: actual %h expected %h", tag, inst, act, exp);
        end
    endtask

    task automatic wr(input logic [11:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_sel = 1'b1; bus_we = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_sel = 1'b0; bus_we = 1'b0;
        for (int i = 0; i < NI; i++) reqv[i] = req_o[i];
    endtask

    task automatic rd(input logic [11:0] a);
        @(negedge clk);
        bus_sel = 1'b1; bus_we = 1'b0; bus_addr = a;
        #1;
        for (int i = 0; i < NI; i++) rv[i] = rdata[i];
    endtask

    function automatic bit implemented(input int a);
        case (a)
            'h00, 'h08, 'h20, 'h30, 'h38, 'h40, 'h44, 'h48,
            'h50, 'h5C, 'h84, 'h88: return 1'b1;
            default: return 1'b0;
        endcase
    endfunction

    function automatic bit writable(input int a);
        case (a)
            'h08, 'h20, 'h30, 'h34, 'h38, 'h3C, 'h40, 'h50: return 1'b1;
            default: return 1'b0;
        endcase
    endfunction

    task automatic summary();
        $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_err++;
            $display("FAIL watchdog: actual timeout expected completion");
            summary();
            $finish;
        end
    end

    initial begin
        logic [31:0] fl, nv, w, a0, dexp [NI], snap [NI][6];
        repeat (4) @(negedge clk);
        pwr_rst = 1'b0;

        // R8 / R1: state after power-on reset
        rd(12'h00); for (int i = 0; i < NI; i++) chk("R1 id", i, rv[i], IDS[i]);
        rd(12'h84); for (int i = 0; i < NI; i++) chk("R1 proc0", i, rv[i], 32'h11 + 32'(i));
        rd(12'h88); for (int i = 0; i < NI; i++) chk("R1 proc1", i, rv[i], 32'hFF00_0000);
        rd(12'h08); for (int i = 0; i < NI; i++) chk("R8 led reset", i, rv[i], 0);
        rd(12'h20); for (int i = 0; i < NI; i++) chk("R8 lock reset", i, rv[i], 0);
        rd(12'h30); for (int i = 0; i < NI; i++) chk("R8 flags reset", i, rv[i], 0);
        rd(12'h38); for (int i = 0; i < NI; i++) chk("R7 nv reset", i, rv[i], 0);
        rd(12'h40); for (int i = 0; i < NI; i++) chk("R8 level reset", i, rv[i], 0);
        rd(12'h50);
        for (int i = 0; i < NI; i++) begin
            chk("R9 disp reset", i, rv[i], (kind(i) == 3) ? 32'h0 : 32'h1F00);
            chk("R10 fmt reset", i, 32'(fmt_o[i]), 0);
            chk("R5 req idle", i, 32'(req_o[i]), 0);
        end

        // R1: identification ignores writes
        wr(12'h00, 32'hFFFF_FFFF);
        rd(12'h00); for (int i = 0; i < NI; i++) chk("R1 id ro", i, rv[i], IDS[i]);

        // R2: LED word
        for (int k = 0; k < 8; k++) begin
            w = (32'h0101_0101 << k) ^ (32'(k) * 32'h0123_4567);
            wr(12'h08, w);
            rd(12'h08);
            for (int i = 0; i < NI; i++) begin
                chk("R2 led read", i, rv[i], w);
                chk("R2 led pins", i, 32'(led_o[i]), w & 32'hFF);
            end
        end

        // R3: lock key
        for (int k = 0; k < 6; k++) begin
            case (k)
                0: w = 32'h0000_A05F;
                1: w = 32'h1234_F0F0;
                2: w = 32'h0001_A05F;
                3: w = 32'h0000_FFFF;
                4: w = 32'h0000_205F;
                default: w = 32'h0000_A05F;
            endcase
            wr(12'h20, w);
            rd(12'h20);
            for (int i = 0; i < NI; i++)
                chk("R3 lock", i, rv[i], (w == 32'h0000_A05F) ? 32'hA05F : (w & 32'h7FFF));
        end

        // R4 / R5: reset control gated by lock
        wr(12'h08, 32'h0000_005A);
        wr(12'h20, 32'h0);
        wr(12'h40, 32'h0000_0104);
        for (int i = 0; i < NI; i++) chk("R4 locked no pulse", i, 32'(reqv[i]), 0);
        rd(12'h40); for (int i = 0; i < NI; i++) chk("R4 locked no store", i, rv[i], 0);
        wr(12'h20, 32'h0000_A05F);
        for (int k = 0; k < 5; k++) begin
            case (k)
                0: w = 32'h0000_0104;
                1: w = 32'h0000_0004;
                2: w = 32'h0000_0100;
                3: w = 32'hFFFF_FEFB;
                default: w = 32'h0000_0000;
            endcase
            wr(12'h40, w);
            for (int i = 0; i < NI; i++)
                chk("R5 pulse", i, 32'(reqv[i]),
                    (kind(i) == 0) ? 32'(w[8]) : (kind(i) == 2) ? 32'(w[2]) : 0);
            @(negedge clk);
            for (int i = 0; i < NI; i++) chk("R5 pulse ends", i, 32'(req_o[i]), 0);
            rd(12'h40);
            for (int i = 0; i < NI; i++)
                chk("R4 level", i, rv[i], (kind(i) == 0 || kind(i) == 2) ? w : 0);
        end
        wr(12'h40, 32'h0000_0104);
        wr(12'h20, 32'h0000_1111);
        wr(12'h40, 32'h0000_0104 ^ 32'h8);
        for (int i = 0; i < NI; i++) chk("R4 relocked no pulse", i, 32'(reqv[i]), 0);
        rd(12'h40);
        for (int i = 0; i < NI; i++)
            chk("R4 relocked keeps", i, rv[i], (kind(i) == 0 || kind(i) == 2) ? 32'h104 : 0);
        rd(12'h08); for (int i = 0; i < NI; i++) chk("R5 bank not reset", i, rv[i], 32'h5A);

        // R6 / R7: set/clear flags
        fl = 0; nv = 0;
        for (int k = 0; k < 12; k++) begin
            w = 32'h9E37_79B9 * 32'(k + 1);
            if (k % 3 == 2) begin
                wr(12'h34, w); fl = fl & ~w;
                wr(12'h38, w); nv = nv | w;
            end else begin
                wr(12'h30, w); fl = fl | w;
                wr(12'h3C, w ^ 32'hFFFF_0000); nv = nv & ~(w ^ 32'hFFFF_0000);
            end
            rd(12'h30); for (int i = 0; i < NI; i++) chk("R6 flags", i, rv[i], fl);
            rd(12'h38); for (int i = 0; i < NI; i++) chk("R7 nv flags", i, rv[i], nv);
        end
        rd(12'h34); for (int i = 0; i < NI; i++) chk("R6 clear reads 0", i, rv[i], 0);
        wr(12'h38, 32'h0000_0055); nv = nv | 32'h55;

        // R8: soft reset
        wr(12'h20, 32'h0000_A05F);
        wr(12'h50, 32'h0000_00FF);
        @(negedge clk); rst = 1'b1;
        @(negedge clk); rst = 1'b0;
        rd(12'h5C); for (int i = 0; i < NI; i++) chk("R13 tick after reset", i, rv[i], 1);
        rd(12'h08); for (int i = 0; i < NI; i++) chk("R8 soft led", i, rv[i], 0);
        rd(12'h20); for (int i = 0; i < NI; i++) chk("R8 soft lock", i, rv[i], 0);
        rd(12'h30); for (int i = 0; i < NI; i++) chk("R8 soft flags", i, rv[i], 0);
        rd(12'h40); for (int i = 0; i < NI; i++) chk("R8 soft level", i, rv[i], 0);
        rd(12'h38); for (int i = 0; i < NI; i++) chk("R7 nv kept", i, rv[i], nv);
        rd(12'h50);
        for (int i = 0; i < NI; i++) begin
            chk("R8 soft disp", i, rv[i], (kind(i) == 3) ? 32'h0 : 32'h1F00);
            chk("R8 soft fmt", i, 32'(fmt_o[i]), 0);
            dexp[i] = rv[i];
        end

        // R9 / R10: display word
        for (int k = 0; k < 6; k++) begin
            case (k)
                0: w = 32'hFFFF_FFFF;
                1: w = 32'h0000_0000;
                2: w = 32'h0000_0083;
                3: w = 32'h0000_0002;
                4: w = 32'hA5A5_A5A5;
                default: w = 32'h0000_3F01;
            endcase
            wr(12'h50, w);
            for (int i = 0; i < NI; i++) begin
                case (kind(i))
                    0, 1: dexp[i] = (dexp[i] & 32'h3F00) | (w & ~32'h3F00);
                    2:    dexp[i] = (dexp[i] & 32'h80) | (w & ~32'h80);
                    default: ;
                endcase
            end
            rd(12'h50);
            for (int i = 0; i < NI; i++) begin
                chk("R9 disp", i, rv[i], dexp[i]);
                chk("R10 fmt", i, 32'(fmt_o[i]), (kind(i) == 0) ? (w & 32'h3) : 0);
            end
        end

        // R11: card status
        for (int c = 0; c < 4; c++) begin
            @(negedge clk);
            card_present = c[0]; card_wprot = c[1];
            wr(12'h48, 32'hFFFF_FFFF);
            rd(12'h48);
            for (int i = 0; i < NI; i++)
                chk("R11 card", i, rv[i],
                    32'(c[0]) | (32'(c[1]) << ((kind(i) < 2) ? 2 : 1)));
        end

        // R12: reserved offsets read zero and ignore writes
        wr(12'h08, 32'h0000_0033);
        wr(12'h30, 32'h0000_0F0F);
        rd(12'h08); for (int i = 0; i < NI; i++) snap[i][0] = rv[i];
        rd(12'h20); for (int i = 0; i < NI; i++) snap[i][1] = rv[i];
        rd(12'h30); for (int i = 0; i < NI; i++) snap[i][2] = rv[i];
        rd(12'h38); for (int i = 0; i < NI; i++) snap[i][3] = rv[i];
        rd(12'h40); for (int i = 0; i < NI; i++) snap[i][4] = rv[i];
        rd(12'h50); for (int i = 0; i < NI; i++) snap[i][5] = rv[i];
        for (int a = 0; a < 'h100; a += 4) begin
            if (!implemented(a)) begin
                rd(12'(a));
                for (int i = 0; i < NI; i++) chk("R12 reserved read", i, rv[i], 0);
            end
        end
        foreach (IDS[j]) begin
            a0 = (j == 0) ? 32'h100 : (j == 1) ? 32'h400 : (j == 2) ? 32'hFFC : 32'h802;
            rd(a0[11:0]);
            for (int i = 0; i < NI; i++) chk("R12 high offset read", i, rv[i], 0);
        end
        for (int a = 0; a < 'h100; a += 4) begin
            if (!writable(a)) begin
                wr(12'(a), 32'hFFFF_FFFF);
                for (int i = 0; i < NI; i++)
                    if (reqv[i] !== 1'b0) chk("R12 write no pulse", i, 32'(reqv[i]), 0);
            end
        end
        rd(12'h08); for (int i = 0; i < NI; i++) chk("R12 led kept", i, rv[i], snap[i][0]);
        rd(12'h20); for (int i = 0; i < NI; i++) chk("R12 lock kept", i, rv[i], snap[i][1]);
        rd(12'h30); for (int i = 0; i < NI; i++) chk("R12 flags kept", i, rv[i], snap[i][2]);
        rd(12'h38); for (int i = 0; i < NI; i++) chk("R12 nv kept", i, rv[i], snap[i][3]);
        rd(12'h40); for (int i = 0; i < NI; i++) chk("R12 level kept", i, rv[i], snap[i][4]);
        rd(12'h50); for (int i = 0; i < NI; i++) chk("R12 disp kept", i, rv[i], snap[i][5]);
        rd(12'h44); for (int i = 0; i < NI; i++) chk("R12 pci one", i, rv[i], 1);

        // R13: tick counter increments and wraps
        for (int n = 0; n < 4; n++) begin
            int gap;
            logic [31:0] first [NI];
            gap = (n == 0) ? 0 : (n == 1) ? 9 : (n == 2) ? 254 : 299;
            rd(12'h5C); for (int i = 0; i < NI; i++) first[i] = rv[i];
            repeat (gap) @(negedge clk);
            rd(12'h5C);
            for (int i = 0; i < NI; i++) begin
                chk("R13 tick width", i, rv[i] & 32'hFFFF_FF00, 0);
                chk("R13 tick delta", i, (rv[i] - first[i]) & 32'hFF, 32'((gap + 1) % 256));
            end
        end

        // R7: power-on reset clears non-volatile flags
        @(negedge clk); pwr_rst = 1'b1;
        @(negedge clk); pwr_rst = 1'b0;
        rd(12'h38); for (int i = 0; i < NI; i++) chk("R7 nv power clear", i, rv[i], 0);

        done = 1'b1;
        summary();
        $finish;
    end

endmodule